// File: doc/BRIEF.md
# Serial Peripheral Slave Shifter with Select Gating

This block is the receive and transmit engine of a byte-wide SPI slave. The serial clock, select and data come from an external master. The block brings them into the faster system clock domain through two-flop synchronizers and detects serial clock edges on the synchronized copy. Data moves most significant bit first in both directions at the same time. When the last bit of a byte is captured, the block raises a one-cycle interrupt pulse and places the received byte in a single-entry output buffer.

A four-bit mode code sets how the select input is treated. With select gating on, a high select level holds the engine in reset and releases the data output at once, even in the middle of a byte. With select gating off, select is ignored. Clearing the enable also aborts any byte in progress.

Transmit bytes enter on a valid/ready port. Its `tx_ready` is always high, so this port never applies back-pressure. A write that arrives while a byte is being shifted is dropped and flagged. Received bytes leave on a valid/ready port. A byte stays presented until `rx_ready` takes it. If a newer byte completes before that, the newer byte is lost and a flag is set.

The serial clock's high and low phases must each last at least 4 system clocks. Change `ckp`, `cke` and `mode` only while the engine is disabled or deselected.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, `rx_valid`, `irq`, `overflow` and `wcol` are 0 and `tx_ready` is 1.
- R2: With mode 4'b0100 and `ssel_n` low, for every combination of `ckp` (the idle level of `sck`) and `cke`, a byte is exchanged most significant bit first. With `cke`=1, SDI is sampled on the idle-to-active edge and the next SDO bit is launched on the active-to-idle edge. With `cke`=0 these two edges swap roles. The first SDO bit is presented as soon as the byte is loaded.
- R3: Only mode codes 4'b0100 (select gated) and 4'b0101 (select ignored) run the engine. With any other code, or with `enable`=0, nothing is shifted, no byte completes and `sdo_oe` is 0.
- R4: `sdo_oe` is 1 exactly when the engine runs, `sdo_off` is 0, and either select is ignored or `ssel_n` is low. It falls combinationally when `ssel_n` rises.
- R5: In mode 4'b0100, raising `ssel_n` partway through a byte zeroes the bit counter. The partial byte produces no completion, and the next full byte is received correctly.
- R6: Clearing `enable` partway through a byte aborts it in the same way as R5. It also clears `overflow` and `wcol`.
- R7: When a byte completes, `irq` is high for one cycle and `rx_valid` is high on the following cycle.
- R8: `rx_valid` stays high with `rx_data` unchanged until a cycle in which `rx_ready` is high.
- R9: If a byte completes while `rx_valid` is high and `rx_ready` is low, `overflow` is set and stays set, and `rx_data` keeps the older byte.
- R10: A transmit write accepted while a byte is in progress is discarded and sets `wcol`. The byte in flight continues unchanged.
- R11: In mode 4'b0101, `cke` is treated as 0.
- R12: A byte that starts without a fresh transmit load sends 0x00. This applies after a completed byte and after an aborted one.
- R13: With `sdo_off`=1, `sdo_oe` is 0 and reception proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; clearing it aborts the current byte and clears the flags |
| mode | input | 4 | Operating code: 4'b0100 select gated, 4'b0101 select ignored |
| ckp | input | 1 | Idle level of the serial clock |
| cke | input | 1 | Edge choice (see R2); forced to 0 in mode 4'b0101 |
| sdo_off | input | 1 | Turns the SDO driver off for shared-wire use |
| sck | input | 1 | Serial clock from the master |
| ssel_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the SDO pad |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Always 1 |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_data | output | DATA_W | Received byte |
| irq | output | 1 | One-cycle pulse per completed byte |
| overflow | output | 1 | Sticky: a byte was lost because the buffer was full |
| wcol | output | 1 | Sticky: a transmit write arrived mid-byte |

## Verification
The bench sweeps all four clock polarity and edge combinations across a set of byte patterns that includes all-zero, all-one and alternating values. It compares both directions against the master's own bit bookkeeping, so an engine that swapped launch and sample edges, or shifted least significant bit first, would return scrambled bytes. Select and enable are pulled partway through a byte: a design that kept its bit count would misalign the next byte, and one that kept stale transmit data would send it. The bench also covers an unread buffer hit by a second byte, a transmit write during shifting, an unsupported mode code and the SDO-off control. In these cases a faulty engine would overwrite the held byte, corrupt the byte in flight, shift while it should be idle, or drive the shared wire.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam logic [3:0] MODE_SEL_GATED = 4'b0100;
  localparam logic [3:0] MODE_SEL_FREE  = 4'b0101;

  typedef struct packed {
    logic run;
    logic sel_ctl;
    logic cke_eff;
    logic ckp;
  } spi_cfg_t;
endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= RST_VAL;
        else        stg[k] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= RST_VAL;
        else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sel_edge.sv
module spi_sel_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic idle_lvl,
  output logic lead,
  output logic trail
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  // leading edge leaves the idle level, trailing edge returns to it
  assign lead  = (prev == idle_lvl) && (lvl != idle_lvl);
  assign trail = (prev != idle_lvl) && (lvl == idle_lvl);
endmodule

// File: rtl/spi_sel_core.sv
module spi_sel_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sel_ctl,
  input  logic              cke_eff,
  input  logic              sel_n_s,
  input  logic              lead,
  input  logic              trail,
  input  logic              sdi_s,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_bit,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              wcol
);
  localparam int               CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              active, busy, samp;
  logic [DATA_W-1:0] rx_next;

  assign active  = run && !(sel_ctl && sel_n_s);
  assign busy    = (cnt != '0) || pend;
  assign samp    = cke_eff ? lead : trail;
  assign rx_next = {rx_sr[DATA_W-2:0], sdi_s};
  assign tx_bit  = tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pend    <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
      wcol    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run)                               wcol <= 1'b0;
      else if (tx_valid && active && busy)    wcol <= 1'b1;

      if (!active) begin
        cnt  <= '0;
        pend <= 1'b0;
        if (busy) tx_sr <= '0;          // aborted byte drops its data
      end else if (samp) begin
        rx_sr <= rx_next;
        if (cnt == LAST) begin
          cnt     <= '0;
          pend    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rx_next;
          tx_sr   <= '0;
        end else begin
          cnt  <= cnt + 1'b1;
          pend <= 1'b1;
        end
      end else if ((lead || trail) && pend) begin
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        pend  <= 1'b0;
      end

      if (tx_valid && !(active && busy)) tx_sr <= tx_data;
    end
  end

  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0 && !pend));

  assert_wcol_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active && busy && tx_valid) |=> wcol);

  assert_wcol_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wcol);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/spi_sel_rxbuf.sv
module spi_sel_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      ovf      <= 1'b0;
    end else begin
      if (done) begin
        if (rx_valid && !rx_ready) begin
          ovf <= 1'b1;
        end else begin
          rx_data  <= byte_in;
          rx_valid <= 1'b1;
        end
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (!run) ovf <= 1'b0;
    end
  end

  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done && rx_valid && !rx_ready) |=> (ovf && $stable(rx_data)));

  assert_valid_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid);

  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [3:0]        mode,
  input  logic              ckp,
  input  logic              cke,
  input  logic              sdo_off,
  input  logic              sck,
  input  logic              ssel_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq,
  output logic              overflow,
  output logic              wcol
);
  spi_cfg_t    cfg;
  logic [2:0]  pins_s;
  logic        sck_s, sel_n_s, sdi_s;
  logic        lead, trail, done;
  logic [DATA_W-1:0] rx_byte;

  always_comb begin
    cfg.sel_ctl = (mode == MODE_SEL_GATED);
    cfg.run     = enable && (cfg.sel_ctl || (mode == MODE_SEL_FREE));
    cfg.cke_eff = cke && cfg.sel_ctl;
    cfg.ckp     = ckp;
  end

  spi_sel_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, ssel_n, sdi}), .q(pins_s)
  );
  assign {sck_s, sel_n_s, sdi_s} = pins_s;

  spi_sel_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .idle_lvl(cfg.ckp),
    .lead(lead), .trail(trail)
  );

  spi_sel_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .sel_ctl(cfg.sel_ctl),
    .cke_eff(cfg.cke_eff), .sel_n_s(sel_n_s), .lead(lead), .trail(trail),
    .sdi_s(sdi_s), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_bit(sdo), .done(done), .rx_byte(rx_byte), .wcol(wcol)
  );

  spi_sel_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .done(done), .byte_in(rx_byte),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .ovf(overflow)
  );

  // raw select so the driver lets go without synchronizer delay
  assign sdo_oe   = cfg.run && !sdo_off && !(cfg.sel_ctl && ssel_n);
  assign tx_ready = 1'b1;
  assign irq      = done;
endmodule

// File: tb/spi_sel_slave_tb.sv
module spi_sel_slave_tb;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] mode = 4'b0100;
  logic       ckp = 1'b0, cke = 1'b0, sdo_off = 1'b0;
  logic       sck = 1'b0, ssel_n = 1'b1, sdi = 1'b0;
  logic       sdo, sdo_oe, tx_ready, rx_valid, irq, overflow, wcol;
  logic       tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = '0, rx_data;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic irq_prev = 1'b0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  spi_sel_slave u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .ckp(ckp), .cke(cke),
    .sdo_off(sdo_off), .sck(sck), .ssel_n(ssel_n), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq),
    .overflow(overflow), .wcol(wcol)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7: irq followed one cycle later by rx_valid
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (irq_prev) chk(rx_valid == 1'b1, "R7 rx_valid after irq", rx_valid, 1);
      if (irq_prev) chk(irq == 1'b0, "R7 irq one cycle", irq, 0);
    end
    irq_prev = irq;
  end

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1; clk_n(1); tx_valid = 1'b0;
  endtask

  task automatic take();
    rx_ready = 1'b1; clk_n(1); rx_ready = 1'b0;
  endtask

  // master: bits hi down to lo; ce is the effective edge choice
  task automatic shift_bits(input logic [7:0] mb, input int hi, input int lo, input bit ce);
    for (int i = hi; i >= lo; i--) begin
      if (ce) begin
        sdi = mb[i]; clk_n(H); got[i] = sdo; sck = ~ckp; clk_n(H); sck = ckp;
      end else begin
        sck = ~ckp; sdi = mb[i]; clk_n(H); got[i] = sdo; sck = ckp; clk_n(H);
      end
    end
    clk_n(H);
  endtask

  task automatic full_byte(input logic [7:0] mb, input bit ce, input bit gated);
    got = '0;
    if (gated) ssel_n = 1'b0;
    clk_n(4);
    shift_bits(mb, 7, 0, ce);
    if (gated) ssel_n = 1'b1;
    clk_n(4);
  endtask

  initial begin
    int base;
    logic [7:0] tb, mb;
    clk_n(5);
    rst_n = 1'b1;
    clk_n(2);
    chk(rx_valid == 0 && irq == 0, "R1 reset valid/irq", {rx_valid, irq}, 0);
    chk(overflow == 0 && wcol == 0, "R1 reset flags", {overflow, wcol}, 0);
    chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
    chk(sdo_oe == 0, "R3 disabled sdo_oe", sdo_oe, 0);

    // R2 sweep over ckp/cke and patterns, mode 0100
    mode = 4'b0100; enable = 1'b1;
    for (int c = 0; c < 4; c++) begin
      ckp = c[1]; cke = c[0]; sck = ckp; clk_n(8);
      for (int p = 0; p < 8; p++) begin
        tb = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'(p * 37 + c);
        mb = ~tb ^ 8'(p * 11);
        base = irq_cnt;
        load(tb);
        ssel_n = 1'b0; #1;
        chk(sdo_oe == 1, "R4 sdo_oe selected", sdo_oe, 1);
        got = '0; clk_n(4);
        shift_bits(mb, 7, 0, cke);
        ssel_n = 1'b1; #1;
        chk(sdo_oe == 0, "R4 sdo_oe released", sdo_oe, 0);
        clk_n(4);
        chk(got == tb, "R2 sdo byte", got, tb);
        chk(rx_valid && rx_data == mb, "R2 rx byte", rx_data, mb);
        chk(irq_cnt == base + 1, "R7 one irq", irq_cnt, base + 1);
        take();
        chk(rx_valid == 0 && overflow == 0, "R8 consumed", {rx_valid, overflow}, 0);
      end
    end

    // mode 0101: select ignored, cke forced 0
    enable = 1'b0; mode = 4'b0101; cke = 1'b1; ckp = 1'b0; sck = 1'b0; clk_n(8);
    enable = 1'b1; clk_n(2);
    chk(sdo_oe == 1, "R4 free mode sdo_oe", sdo_oe, 1);
    load(8'hC3);
    full_byte(8'h3C, 1'b0, 1'b0);
    chk(got == 8'hC3, "R11 tx in 0101", got, 8'hC3);
    chk(rx_valid && rx_data == 8'h3C, "R3 R11 rx in 0101", rx_data, 8'h3C);
    take();
    full_byte(8'h96, 1'b0, 1'b0);
    chk(got == 8'h00, "R12 no reload sends zero", got, 0);
    chk(rx_data == 8'h96, "R3 second byte", rx_data, 8'h96);
    take();

    // unsupported code
    mode = 4'b0110; clk_n(4);
    chk(sdo_oe == 0, "R3 bad code sdo_oe", sdo_oe, 0);
    base = irq_cnt;
    full_byte(8'h81, 1'b0, 1'b1);
    chk(irq_cnt == base && rx_valid == 0, "R3 bad code idle", irq_cnt, base);

    // abort by select
    mode = 4'b0100; cke = 1'b1; clk_n(4);
    load(8'hF0);
    ssel_n = 1'b0; clk_n(4);
    shift_bits(8'hAA, 7, 5, 1'b1);
    ssel_n = 1'b1; #1;
    chk(sdo_oe == 0, "R4 immediate release", sdo_oe, 0);
    base = irq_cnt;
    clk_n(6);
    full_byte(8'h55, 1'b1, 1'b1);
    chk(rx_data == 8'h55, "R5 realigned after abort", rx_data, 8'h55);
    chk(got == 8'h00, "R12 aborted data dropped", got, 0);
    chk(irq_cnt == base + 1, "R5 partial no irq", irq_cnt, base + 1);
    take();
    load(8'h0F);
    full_byte(8'hE7, 1'b1, 1'b1);
    chk(got == 8'h0F && rx_data == 8'hE7, "R5 next byte", {got, rx_data}, 16'h0FE7);
    take();

    // overflow
    full_byte(8'h11, 1'b1, 1'b1);
    chk(rx_valid == 1, "R8 held", rx_valid, 1);
    full_byte(8'h22, 1'b1, 1'b1);
    chk(overflow == 1, "R9 overflow set", overflow, 1);
    chk(rx_data == 8'h11, "R9 old byte kept", rx_data, 8'h11);
    take();
    chk(rx_valid == 0, "R8 released", rx_valid, 0);
    chk(overflow == 1, "R9 sticky", overflow, 1);

    // write collision
    load(8'h12);
    got = '0; ssel_n = 1'b0; clk_n(4);
    shift_bits(8'h6D, 7, 4, 1'b1);
    load(8'h99);
    chk(wcol == 1, "R10 wcol set", wcol, 1);
    shift_bits(8'h6D, 3, 0, 1'b1);
    ssel_n = 1'b1; clk_n(4);
    chk(got == 8'h12, "R10 flight unchanged", got, 8'h12);
    chk(rx_data == 8'h6D, "R10 rx ok", rx_data, 8'h6D);
    take();

    // abort by enable
    load(8'h77);
    ssel_n = 1'b0; clk_n(4);
    shift_bits(8'hC0, 7, 5, 1'b1);
    enable = 1'b0; base = irq_cnt; clk_n(4);
    chk(wcol == 0 && overflow == 0, "R6 flags cleared", {wcol, overflow}, 0);
    enable = 1'b1; ssel_n = 1'b1; clk_n(4);
    load(8'h3E);
    full_byte(8'hE3, 1'b1, 1'b1);
    chk(got == 8'h3E && rx_data == 8'hE3, "R6 realigned", {got, rx_data}, 16'h3EE3);
    chk(irq_cnt == base + 1, "R6 partial no irq", irq_cnt, base + 1);
    take();

    // driver off
    sdo_off = 1'b1; ssel_n = 1'b0; #1;
    chk(sdo_oe == 0, "R13 sdo_oe off", sdo_oe, 0);
    ssel_n = 1'b1;
    full_byte(8'h5B, 1'b1, 1'b1);
    chk(rx_valid && rx_data == 8'h5B, "R13 rx continues", rx_data, 8'h5B);
    take();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule